// File: doc/BRIEF.md
# Epoch-Based Replacement Threshold Selector

This block chooses which replacement threshold a large last-level cache uses. A small number of sampled cache sets run shadow tags, and each candidate threshold is emulated in its own shadow copy. Whenever a shadow copy sees a miss or writes back a dirty line, it sends a one-cycle pulse on that candidate's miss or writeback input. The selector adds these pulses into one cost counter per candidate.

Time is divided into epochs of a fixed number of cache accesses, announced one per cycle on an access strobe. When the last access of an epoch arrives, the selector finds the candidate with the smallest cost (misses plus writebacks) and makes it the active threshold. It then clears all costs and raises an epoch-end strobe for one cycle. The selector sits beside the access path and does not gate any lookup.

Top module: `ps_policy_sel`

## Requirements
- R1: After reset the selected candidate index is DEF_IDX (default 4), the threshold output is THR_BASE + DEF_IDX*THR_STEP (default 8), and the epoch-end strobe is low.
- R2: An epoch closes on the cycle that carries its EPOCH_LEN-th access (a cycle with acc_vld high). Cycles with acc_vld low do not advance the epoch. epoch_end is high in the cycle after the closing access, for exactly one cycle.
- R3: Each candidate's cost rises by one for each miss pulse and by one for each writeback pulse. A miss pulse and a writeback pulse in the same cycle add two.
- R4: At epoch close, the candidate with the lowest cost becomes the selected index (bit i of the event vectors belongs to candidate i). The new index and threshold are visible in the same cycle that epoch_end is high.
- R5: When candidates share the lowest cost, the one with the smallest index wins.
- R6: All cost counters return to zero after an epoch closes, so each decision uses only the events of its own epoch.
- R7: A cost counter that reaches 2^CNT_W-1 stays there instead of wrapping.
- R8: The threshold output always equals THR_BASE + index*THR_STEP, and the selection changes only in a cycle where epoch_end is high.
- R9: Until the first epoch closes, the default candidate stays selected.
- R10: Pulses that arrive in the cycle of the closing access are counted in the epoch being closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | One cache access this cycle |
| miss_ev | input | NUM_CAND | Per-candidate shadow miss pulse |
| wb_ev | input | NUM_CAND | Per-candidate shadow writeback pulse |
| epoch_end | output | 1 | One-cycle strobe: a new selection was just made |
| cand_sel | output | $clog2(NUM_CAND) | Index of the active candidate |
| thr_sel | output | THR_W | Active replacement threshold |

## Verification
The selection is tested with several event patterns, each built so that a specific wrong design would pick a different winner:
- A mix of miss-only, writeback-only and coincident pulses makes a different candidate win if writebacks were dropped or coincident pulses counted once.
- Events placed at the tail of an epoch tell apart whether the closing cycle is counted.
- An equal-cost pattern checks that the lower index wins a tie.
- An empty epoch following a lopsided one shows whether the costs were cleared.
- Overloaded candidates pick a different winner if the counters wrapped instead of saturating.

Accesses spread out with idle gaps check that only strobed cycles advance the epoch.

// File: rtl/ps_pkg.sv
package ps_pkg;

    // One candidate's shadow events in a single cycle
    typedef struct packed {
        logic miss;
        logic wb;
    } ps_event_t;

    // Cost added by one cycle of events: 0, 1 or 2
    function automatic logic [1:0] ps_weight(input ps_event_t ev);
        return {1'b0, ev.miss} + {1'b0, ev.wb};
    endfunction

    // Threshold value that belongs to a candidate index
    function automatic int ps_thr_of(input int idx, input int base, input int step);
        return base + idx * step;
    endfunction

endpackage

// File: rtl/ps_epoch_timer.sv
module ps_epoch_timer #(
    parameter int EPOCH_LEN = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic acc_vld,
    output logic close
);
    localparam int ECNT_W = (EPOCH_LEN > 1) ? $clog2(EPOCH_LEN) : 1;
    localparam logic [ECNT_W-1:0] LAST = ECNT_W'(EPOCH_LEN - 1);

    logic [ECNT_W-1:0] cnt_q;

    assign close = acc_vld && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (close) begin
            cnt_q <= '0;
        end else if (acc_vld) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ps_cost_counter.sv
module ps_cost_counter
    import ps_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  ps_event_t        ev,
    output logic [CNT_W-1:0] cost_nxt
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] cost_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum      = {1'b0, cost_q} + {{(CNT_W - 1){1'b0}}, ps_weight(ev)};
        cost_nxt = sum[CNT_W] ? CMAX : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cost_q <= '0;
        end else begin
            cost_q <= cost_nxt;
        end
    end
endmodule

// File: rtl/ps_argmin.sv
module ps_argmin #(
    parameter int NUM_CAND = 9,
    parameter int CNT_W    = 16,
    localparam int IDX_W   = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1
) (
    input  logic [NUM_CAND-1:0][CNT_W-1:0] cost,
    output logic [IDX_W-1:0]               win
);
    logic [CNT_W-1:0] best;

    always_comb begin
        best = cost[0];
        win  = '0;
        for (int i = 1; i < NUM_CAND; i++) begin
            if (cost[i] < best) begin
                best = cost[i];
                win  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ps_policy_sel.sv
module ps_policy_sel
    import ps_pkg::*;
#(
    parameter int NUM_CAND  = 9,
    parameter int EPOCH_LEN = 25000,
    parameter int CNT_W     = 16,
    parameter int THR_W     = 5,
    parameter int THR_BASE  = 4,
    parameter int THR_STEP  = 1,
    parameter int DEF_IDX   = 4,
    localparam int IDX_W    = (NUM_CAND > 1) ? $clog2(NUM_CAND) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_vld,
    input  logic [NUM_CAND-1:0] miss_ev,
    input  logic [NUM_CAND-1:0] wb_ev,
    output logic                epoch_end,
    output logic [IDX_W-1:0]    cand_sel,
    output logic [THR_W-1:0]    thr_sel
);
    logic                          close;
    logic [NUM_CAND-1:0][CNT_W-1:0] cost_nxt;
    logic [IDX_W-1:0]              win;

    ps_epoch_timer #(.EPOCH_LEN(EPOCH_LEN)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .acc_vld (acc_vld),
        .close   (close)
    );

    for (genvar g = 0; g < NUM_CAND; g++) begin : g_cost
        ps_event_t ev;
        assign ev.miss = miss_ev[g];
        assign ev.wb   = wb_ev[g];
        ps_cost_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .clr      (close),
            .ev       (ev),
            .cost_nxt (cost_nxt[g])
        );
    end

    ps_argmin #(.NUM_CAND(NUM_CAND), .CNT_W(CNT_W)) u_min (
        .cost (cost_nxt),
        .win  (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_sel  <= IDX_W'(DEF_IDX);
            epoch_end <= 1'b0;
        end else begin
            epoch_end <= close;
            if (close) begin
                cand_sel <= win;
            end
        end
    end

    assign thr_sel = THR_W'(ps_thr_of(int'(cand_sel), THR_BASE, THR_STEP));
endmodule

// File: rtl/ps_policy_sel_chk.sv
module ps_policy_sel_chk #(
    parameter int NUM_CAND = 9,
    parameter int THR_W    = 5,
    parameter int THR_BASE = 4,
    parameter int THR_STEP = 1,
    parameter int DEF_IDX  = 4,
    parameter int IDX_W    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_vld,
    input logic             epoch_end,
    input logic [IDX_W-1:0] cand_sel,
    input logic [THR_W-1:0] thr_sel
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else if (epoch_end) seen_q <= 1'b1;
    end

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
        epoch_end |=> !epoch_end); // R2

    AST_END_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
        epoch_end |-> $past(acc_vld)); // R2

    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(cand_sel) < NUM_CAND); // R4

    AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !epoch_end |-> $stable(cand_sel)); // R8

    AST_THR_MATCH: assert property (@(posedge clk) disable iff (rst)
        int'(thr_sel) == THR_BASE + int'(cand_sel) * THR_STEP); // R8

    AST_DEFAULT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (!seen_q && !epoch_end) |-> (int'(cand_sel) == DEF_IDX)); // R9
endmodule

bind ps_policy_sel ps_policy_sel_chk #(
    .NUM_CAND (NUM_CAND),
    .THR_W    (THR_W),
    .THR_BASE (THR_BASE),
    .THR_STEP (THR_STEP),
    .DEF_IDX  (DEF_IDX),
    .IDX_W    (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_vld   (acc_vld),
    .epoch_end (epoch_end),
    .cand_sel  (cand_sel),
    .thr_sel   (thr_sel)
);

// File: tb/sim_ps_policy_sel.sv
`timescale 1ns/1ps
module sim_ps_policy_sel;
    localparam int NC = 9;
    localparam int L  = 20;
    localparam int CW = 4;
    localparam int IW = 4;
    localparam int TW = 5;

    typedef int carr_t[NC];

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_vld = 1'b0;
    logic [NC-1:0] miss_ev = '0;
    logic [NC-1:0] wb_ev = '0;
    logic          epoch_end;
    logic [IW-1:0] cand_sel;
    logic [TW-1:0] thr_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ps_policy_sel #(
        .NUM_CAND(NC), .EPOCH_LEN(L), .CNT_W(CW), .THR_W(TW),
        .THR_BASE(4), .THR_STEP(1), .DEF_IDX(4)
    ) u0 (
        .clk(clk), .rst(rst), .acc_vld(acc_vld), .miss_ev(miss_ev),
        .wb_ev(wb_ev), .epoch_end(epoch_end), .cand_sel(cand_sel), .thr_sel(thr_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Full epoch of L accesses. In head mode candidate i pulses in cycles
    // k < count; in tail mode in cycles k >= L - count.
    task automatic drive_epoch(input string req, input carr_t mc, input carr_t wc,
                               input bit tail, input int exp_win);
        int prev;
        bit early;
        prev  = int'(cand_sel);
        early = 1'b0;
        for (int k = 0; k < L; k++) begin
            @(negedge clk);
            if (epoch_end) early = 1'b1;
            acc_vld = 1'b1;
            for (int i = 0; i < NC; i++) begin
                miss_ev[i] = tail ? (k >= L - mc[i]) : (k < mc[i]);
                wb_ev[i]   = tail ? (k >= L - wc[i]) : (k < wc[i]);
            end
        end
        @(negedge clk);
        acc_vld = 1'b0; miss_ev = '0; wb_ev = '0;
        check("R2 no early epoch_end", int'(early), 0);
        check("R2 epoch_end after last access", int'(epoch_end), 1);
        check({req, " winner"}, int'(cand_sel), exp_win);
        check("R8 threshold map", int'(thr_sel), 4 + exp_win);
        @(negedge clk);
        check("R2 epoch_end one cycle", int'(epoch_end), 0);
        check("R8 selection held", int'(cand_sel), exp_win);
        if (prev < 0) check("R8 unused", 0, 1);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset epoch_end", int'(epoch_end), 0);
        check("R1 reset cand_sel", int'(cand_sel), 4);
        check("R1 reset thr_sel", int'(thr_sel), 8);
    endtask

    // Sparse accesses with idle gaps; empty epoch ties at zero, index 0 wins
    task automatic test_timing();
        bit early;
        early = 1'b0;
        for (int k = 0; k < L - 1; k++) begin
            @(negedge clk); acc_vld = 1'b1;
            @(negedge clk); acc_vld = 1'b0;
            if (epoch_end) early = 1'b1;
            @(negedge clk);
            if (epoch_end) early = 1'b1;
        end
        check("R2 idle cycles do not advance epoch", int'(early), 0);
        check("R9 default held before first epoch", int'(cand_sel), 4);
        @(negedge clk); acc_vld = 1'b1;
        @(negedge clk); acc_vld = 1'b0;
        check("R2 epoch_end on last access", int'(epoch_end), 1);
        check("R5 empty epoch tie picks index 0", int'(cand_sel), 0);
        @(negedge clk);
        check("R2 epoch_end one cycle wide", int'(epoch_end), 0);
    endtask

    task automatic test_lowest();
        // costs 9,9,10,7,10,12,8,10,11: R3 both kinds, coincident pulses add two
        drive_epoch("R3 R4 lowest cost",
            '{0, 9, 5, 7, 10, 6, 4, 9, 11},
            '{9, 0, 5, 0, 0, 6, 4, 1, 0}, 1'b0, 3);
    endtask

    task automatic test_closing_cycle();
        // cand3 5 incl. closing cycle, cand5 4; others 10
        drive_epoch("R10 closing-cycle events counted",
            '{10, 10, 10, 3, 10, 4, 10, 10, 10},
            '{0, 0, 0, 2, 0, 0, 0, 0, 0}, 1'b1, 5);
    endtask

    task automatic test_tie();
        drive_epoch("R5 tie lower index",
            '{8, 8, 3, 8, 8, 8, 8, 0, 8},
            '{0, 0, 0, 0, 0, 0, 0, 3, 0}, 1'b0, 2);
    endtask

    task automatic test_clear();
        drive_epoch("R6 costs cleared",
            '{0, 0, 0, 0, 0, 0, 0, 0, 0},
            '{0, 0, 0, 0, 0, 0, 0, 0, 0}, 1'b0, 0);
    endtask

    task automatic test_saturate();
        // 40 events saturate at 15; cand1 has 12
        drive_epoch("R7 saturation",
            '{20, 6, 20, 20, 20, 20, 20, 20, 20},
            '{20, 6, 20, 20, 20, 20, 20, 20, 20}, 1'b0, 1);
    endtask

    initial begin
        test_reset();
        test_timing();
        test_lowest();
        test_closing_cycle();
        test_tie();
        test_clear();
        test_saturate();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule